// File: doc/BRIEF.md
# Neuron Recovery Update and Spike Reset Pipeline

This block is the final stage of a spiking-neuron state update. It takes, for a row of neurons handled side by side, the freshly updated membrane voltage and the previous recovery value. With each neuron's four behaviour parameters it forms the new recovery value as a times the quantity (b times voltage minus old recovery). It then compares the voltage against a fixed firing threshold. A neuron that fires has its voltage replaced by its reset potential c and its recovery value raised by d. A neuron that does not fire passes its voltage and new recovery value through unchanged.

The pipeline has a fixed latency. The voltage, c and d travel through matching delay registers so that the threshold test and the reset multiplexers see them in the same cycle as the recovery result. The per-lane fire bits form one word, which the surrounding core stores for the next time step's synaptic accumulation. A valid flag travels alongside the data. A new row can be accepted on every clock.

Top module: `recovery_spike_unit`

## Requirements
- R1: With a and b as 12-bit signed values carrying 10 fractional bits, and voltage and recovery as 32-bit signed values carrying 8 fractional bits, the recovery result is formed as follows. First bv = (b*v) >>> 10. Then u_new = (a*(bv - u)) >>> 10, truncated to 32 bits. Each shift is arithmetic, so it rounds toward minus infinity.
- R2: A lane fires when its voltage is greater than or equal to 35.0, which is 35*256 in the 8-fraction-bit encoding. A voltage exactly equal to the threshold fires, and one code below it does not.
- R3: When a lane fires, its voltage output is c (32-bit, same scaling as voltage) and its recovery output is u_new plus d. Here d is 16-bit signed with the same scaling, sign-extended before the add.
- R4: When a lane does not fire, its voltage output equals its voltage input and its recovery output equals u_new.
- R5: Each cycle with in_valid high yields exactly one cycle of out_valid high, 4 clock edges later. Rows presented on consecutive cycles come out on consecutive cycles in the same order.
- R6: While out_valid is low, the voltage, recovery and fire outputs keep their last values. Inputs presented with in_valid low have no effect on any output.
- R7: Lanes are independent. Lane i uses bits [i*W +: W] of every packed data port, and spike_out bit i is the fire flag of lane i.
- R8: After reset, out_valid is low and every data output and fire bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input row is valid this cycle |
| v_in | input | LANES*V_W | Updated membrane voltage per lane |
| u_in | input | LANES*U_W | Previous recovery value per lane |
| a_in | input | LANES*AB_W | Recovery decay rate per lane |
| b_in | input | LANES*AB_W | Voltage-to-recovery coupling per lane |
| c_in | input | LANES*C_W | Post-fire voltage reset value per lane |
| d_in | input | LANES*DP_W | Post-fire recovery increment per lane |
| out_valid | output | 1 | Output row is valid this cycle |
| v_out | output | LANES*V_W | Final voltage per lane |
| u_out | output | LANES*U_W | Final recovery value per lane |
| spike_out | output | LANES | Fire flag per lane |

## Verification
Several properties are checked on every clock. The valid flag emerges exactly four edges after it enters. The outputs hold whenever no row completes. In the last stage, a voltage at or above threshold leads to a fired lane carrying c, and a voltage below threshold leads to a quiet lane that passes the voltage through. The arithmetic of the recovery result can only be shown by the directed scenarios: floor rounding on negative intermediates, the d addition, the one-code-below-threshold case, and lane placement within the packed words. These scenarios compare the outputs with an independent model, using the regular-spiking and other parameter sets.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
   // Firing threshold in whole millivolts; scaled by the voltage fraction bits.
   localparam int SPIKE_MV = 35;
   // Clock edges from input capture to output register.
   localparam int PIPE_LAT = 4;
   // Number of edges the side data (v, c, d) is delayed before the reset stage.
   localparam int SIDE_DEPTH = PIPE_LAT - 1;
endpackage

// File: rtl/rsu_delay_line.sv
module rsu_delay_line #(
   parameter int W     = 8,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DEPTH-1:0] en,
   input  logic [W-1:0]     d,
   output logic [W-1:0]     q
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("rsu_delay_line: DEPTH must be at least 1");
   end

   logic [DEPTH-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         if (en[0]) st[0] <= d;
         for (int k = 1; k < DEPTH; k++) begin
            if (en[k]) st[k] <= st[k-1];
         end
      end
   end

   assign q = st[DEPTH-1];
endmodule

// File: rtl/rsu_recovery_lane.sv
module rsu_recovery_lane #(
   parameter int V_W     = 32,
   parameter int U_W     = 32,
   parameter int AB_W    = 12,
   parameter int AB_FRAC = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2:0]            en,
   input  logic signed [V_W-1:0] v_in,
   input  logic signed [U_W-1:0] u_in,
   input  logic signed [AB_W-1:0] a_in,
   input  logic signed [AB_W-1:0] b_in,
   output logic signed [U_W-1:0] u_new
);
   localparam int P1_W = AB_W + V_W;
   localparam int DF_W = ((P1_W > U_W) ? P1_W : U_W) + 1;
   localparam int P2_W = AB_W + DF_W;

   if (AB_FRAC >= AB_W) begin : g_bad_frac
      $error("rsu_recovery_lane: AB_FRAC must be below AB_W");
   end
   if (P2_W < AB_FRAC + U_W) begin : g_bad_p2
      $error("rsu_recovery_lane: product too narrow for result");
   end

   // stage 1: b * v
   logic signed [P1_W-1:0] bv_c, bv_q;
   logic signed [U_W-1:0]  u1_q;
   logic signed [AB_W-1:0] a1_q, a2_q;
   // stage 2: scaled(b*v) - u
   logic signed [DF_W-1:0] df_c, df_q;
   // stage 3: a * diff, rescaled
   logic signed [P2_W-1:0] p2_c;

   assign bv_c = b_in * v_in;
   assign df_c = (bv_q >>> AB_FRAC) - u1_q;
   assign p2_c = a2_q * df_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bv_q  <= '0;
         u1_q  <= '0;
         a1_q  <= '0;
         df_q  <= '0;
         a2_q  <= '0;
         u_new <= '0;
      end else begin
         if (en[0]) begin
            bv_q <= bv_c;
            u1_q <= u_in;
            a1_q <= a_in;
         end
         if (en[1]) begin
            df_q <= df_c;
            a2_q <= a1_q;
         end
         if (en[2]) begin
            u_new <= p2_c[AB_FRAC +: U_W];
         end
      end
   end
endmodule

// File: rtl/rsu_spike_stage.sv
module rsu_spike_stage #(
   parameter int V_W     = 32,
   parameter int U_W     = 32,
   parameter int C_W     = 32,
   parameter int DP_W    = 16,
   parameter int VU_FRAC = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic signed [V_W-1:0]  v_in,
   input  logic signed [C_W-1:0]  c_in,
   input  logic signed [DP_W-1:0] d_in,
   input  logic signed [U_W-1:0]  u_in,
   output logic signed [V_W-1:0]  v_out,
   output logic signed [U_W-1:0]  u_out,
   output logic                   spike
);
   import rsu_pkg::*;

   if (C_W > V_W) begin : g_bad_c
      $error("rsu_spike_stage: C_W must not exceed V_W");
   end
   if (DP_W > U_W) begin : g_bad_d
      $error("rsu_spike_stage: DP_W must not exceed U_W");
   end
   if (V_W < VU_FRAC + 8) begin : g_bad_thr
      $error("rsu_spike_stage: V_W too narrow for threshold");
   end

   localparam logic signed [V_W-1:0] THRESH = V_W'(SPIKE_MV) <<< VU_FRAC;

   logic                  fire;
   logic signed [V_W-1:0] c_ext;
   logic signed [U_W-1:0] d_ext;

   assign fire  = (v_in >= THRESH);
   assign c_ext = V_W'(c_in);
   assign d_ext = U_W'(d_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_out <= '0;
         u_out <= '0;
         spike <= 1'b0;
      end else if (en) begin
         spike <= fire;
         v_out <= fire ? c_ext : v_in;
         u_out <= fire ? (u_in + d_ext) : u_in;
      end
   end

   // R2/R3: a voltage at or above threshold ends as a fired lane holding c
   assert_fire_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && v_in >= THRESH) |=> (spike && v_out == $past(c_ext)));
   // R2/R4: below threshold the lane stays quiet and passes its voltage on
   assert_quiet_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && v_in < THRESH) |=> (!spike && v_out == $past(v_in)));
endmodule

// File: rtl/recovery_spike_unit.sv
module recovery_spike_unit #(
   parameter int LANES   = 4,
   parameter int V_W     = 32,
   parameter int U_W     = 32,
   parameter int AB_W    = 12,
   parameter int AB_FRAC = 10,
   parameter int C_W     = 32,
   parameter int DP_W    = 16,
   parameter int VU_FRAC = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [LANES*V_W-1:0]    v_in,
   input  logic [LANES*U_W-1:0]    u_in,
   input  logic [LANES*AB_W-1:0]   a_in,
   input  logic [LANES*AB_W-1:0]   b_in,
   input  logic [LANES*C_W-1:0]    c_in,
   input  logic [LANES*DP_W-1:0]   d_in,
   output logic                    out_valid,
   output logic [LANES*V_W-1:0]    v_out,
   output logic [LANES*U_W-1:0]    u_out,
   output logic [LANES-1:0]        spike_out
);
   import rsu_pkg::*;

   localparam int SIDE_W = V_W + C_W + DP_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("recovery_spike_unit: LANES must be at least 1");
   end
   if (SIDE_DEPTH != 3) begin : g_bad_lat
      $error("recovery_spike_unit: side delay must match the three arithmetic stages");
   end

   // valid chain: vld[0] is input, vld[k] follows stage k
   logic [PIPE_LAT-1:0] vld_q;
   logic [SIDE_DEPTH-1:0] side_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
   end

   assign side_en   = {vld_q[1:0], in_valid};
   assign out_valid = vld_q[PIPE_LAT-1];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic signed [U_W-1:0]  u_new;
      logic [SIDE_W-1:0]      side_q;
      logic signed [V_W-1:0]  v_dly;
      logic signed [C_W-1:0]  c_dly;
      logic signed [DP_W-1:0] d_dly;

      rsu_recovery_lane #(
         .V_W(V_W), .U_W(U_W), .AB_W(AB_W), .AB_FRAC(AB_FRAC)
      ) u_rec (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (side_en),
         .v_in  (v_in[g*V_W +: V_W]),
         .u_in  (u_in[g*U_W +: U_W]),
         .a_in  (a_in[g*AB_W +: AB_W]),
         .b_in  (b_in[g*AB_W +: AB_W]),
         .u_new (u_new)
      );

      rsu_delay_line #(.W(SIDE_W), .DEPTH(SIDE_DEPTH)) u_side (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (side_en),
         .d     ({v_in[g*V_W +: V_W], c_in[g*C_W +: C_W], d_in[g*DP_W +: DP_W]}),
         .q     (side_q)
      );

      assign {v_dly, c_dly, d_dly} = side_q;

      rsu_spike_stage #(
         .V_W(V_W), .U_W(U_W), .C_W(C_W), .DP_W(DP_W), .VU_FRAC(VU_FRAC)
      ) u_spk (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (vld_q[PIPE_LAT-2]),
         .v_in  (v_dly),
         .c_in  (c_dly),
         .d_in  (d_dly),
         .u_in  (u_new),
         .v_out (v_out[g*V_W +: V_W]),
         .u_out (u_out[g*U_W +: U_W]),
         .spike (spike_out[g])
      );
   end

   // R5: every accepted row surfaces four edges later
   assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##3 out_valid);
   // R6: no completing row means outputs stay put
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q[PIPE_LAT-2] |=> ($stable(v_out) && $stable(u_out) && $stable(spike_out)));
endmodule

// File: tb/tb_recovery_spike_unit.sv
module tb_recovery_spike_unit;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 4;
   localparam int V_W = 32, U_W = 32, AB_W = 12, C_W = 32, DP_W = 16;
   localparam int THR = 35 * 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [LANES*V_W-1:0]  v_in = '0;
   logic [LANES*U_W-1:0]  u_in = '0;
   logic [LANES*AB_W-1:0] a_in = '0;
   logic [LANES*AB_W-1:0] b_in = '0;
   logic [LANES*C_W-1:0]  c_in = '0;
   logic [LANES*DP_W-1:0] d_in = '0;
   logic out_valid;
   logic [LANES*V_W-1:0] v_out;
   logic [LANES*U_W-1:0] u_out;
   logic [LANES-1:0]     spike_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   int tv[8][LANES], tu[8][LANES], ta[8][LANES], tb[8][LANES], tc[8][LANES], td[8][LANES];

   always #(CLK_PERIOD/2) clk = ~clk;

   recovery_spike_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .v_in(v_in), .u_in(u_in), .a_in(a_in), .b_in(b_in), .c_in(c_in), .d_in(d_in),
      .out_valid(out_valid), .v_out(v_out), .u_out(u_out), .spike_out(spike_out)
   );

   // independent behavioural model of one lane
   function automatic void model(input int v, input int u, input int a, input int b,
                                 input int c, input int d,
                                 output int ve, output int ue, output bit se);
      longint bv, df, p;
      int un;
      bv = (longint'(b) * longint'(v)) >>> 10;
      df = bv - longint'(u);
      p  = longint'(a) * df;
      un = int'(p >>> 10);
      se = (v >= THR);
      ve = se ? c : v;
      ue = se ? un + d : un;
   endfunction

   task automatic check(input string req, input bit ok, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_row(input int k, input int l, input int v, input int u,
                          input int a, input int b, input int c, input int d);
      tv[k][l] = v; tu[k][l] = u; ta[k][l] = a; tb[k][l] = b; tc[k][l] = c; td[k][l] = d;
   endtask

   task automatic drive_row(input int k);
      for (int l = 0; l < LANES; l++) begin
         v_in[l*V_W +: V_W]   = tv[k][l];
         u_in[l*U_W +: U_W]   = tu[k][l];
         a_in[l*AB_W +: AB_W] = AB_W'(ta[k][l]);
         b_in[l*AB_W +: AB_W] = AB_W'(tb[k][l]);
         c_in[l*C_W +: C_W]   = tc[k][l];
         d_in[l*DP_W +: DP_W] = DP_W'(td[k][l]);
      end
   endtask

   task automatic check_row(input int k, input string req);
      int ve, ue;
      bit se;
      check(req, out_valid === 1'b1, "out_valid", out_valid, 1);
      for (int l = 0; l < LANES; l++) begin
         model(tv[k][l], tu[k][l], ta[k][l], tb[k][l], tc[k][l], td[k][l], ve, ue, se);
         check(req, $signed(v_out[l*V_W +: V_W]) == ve, $sformatf("lane%0d v", l),
               $signed(v_out[l*V_W +: V_W]), ve);
         check(req, $signed(u_out[l*U_W +: U_W]) == ue, $sformatf("lane%0d u", l),
               $signed(u_out[l*U_W +: U_W]), ue);
         check(req, spike_out[l] == se, $sformatf("lane%0d spike", l), spike_out[l], se);
      end
   endtask

   // single row: drive at a falling edge, sample four rising edges later
   task automatic run_single(input int k, input string req);
      @(negedge clk);
      drive_row(k);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check_row(k, req);
   endtask

   task automatic t_reset;
      check("R8", out_valid === 1'b0, "out_valid", out_valid, 0);
      check("R8", v_out === '0 && u_out === '0, "data", v_out[31:0], 0);
      check("R8", spike_out === '0, "spike", spike_out, 0);
   endtask

   // regular-spiking set, all lanes below threshold, incl. negative floor cases
   task automatic t_subthreshold;
      set_row(0, 0, -65*256, -13*256, 20, 205, -65*256, 8*256);
      set_row(0, 1, -45*256, 12*256, 20, 205, -65*256, 8*256);
      set_row(0, 2, 10*256+37, -3*256+5, 20, 205, -65*256, 8*256);
      set_row(0, 3, 34*256, 100, 20, 205, -65*256, 8*256);
      run_single(0, "R1_R4");
   endtask

   // exact threshold, one below, far above, just negative: spike word 0101
   task automatic t_threshold;
      set_row(1, 0, THR, -2*256, 20, 205, -65*256, 8*256);
      set_row(1, 1, THR-1, -2*256, 20, 205, -65*256, 8*256);
      set_row(1, 2, 120*256, 7*256+3, 20, 205, -65*256, 8*256);
      set_row(1, 3, -1, 0, 20, 205, -65*256, 8*256);
      run_single(1, "R2_R3");
      check("R7", spike_out == 4'b0101, "spike word", spike_out, 4'b0101);
   endtask

   // other parameter sets: chattering, fast-spiking, low-threshold, negative d
   task automatic t_param_sets;
      set_row(2, 0, 50*256, 5*256, 20, 205, -50*256, 2*256);
      set_row(2, 1, 36*256, -9*256+77, 102, 205, -65*256, 2*256);
      set_row(2, 2, 20*256, 3*256, 20, 256, -65*256, 2*256);
      set_row(2, 3, 90*256, -40*256, -30, -300, -70*256, -5*256);
      run_single(2, "R3");
      check("R7", spike_out == 4'b1011, "spike word", spike_out, 4'b1011);
   endtask

   // back-to-back rows come out in order on consecutive cycles
   task automatic t_stream;
      for (int l = 0; l < LANES; l++) begin
         set_row(3, l, (l*20-10)*256, l*300, 20, 205, -65*256, 8*256);
         set_row(4, l, (60-l*15)*256, -l*500, 20, 205, -65*256, 8*256);
         set_row(5, l, (35-l)*256 + l, 1000, 102, 205, -50*256, 2*256);
      end
      for (int cyc = 0; cyc < 7; cyc++) begin
         @(negedge clk);
         if (cyc >= 4) check_row(cyc - 1, "R5");
         if (cyc < 3) begin
            drive_row(cyc + 3);
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      check("R5", out_valid === 1'b0, "out_valid after stream", out_valid, 0);
   endtask

   // inputs without in_valid must not change outputs
   task automatic t_hold;
      logic [LANES*V_W-1:0] v_keep;
      logic [LANES*U_W-1:0] u_keep;
      logic [LANES-1:0] s_keep;
      v_keep = v_out; u_keep = u_out; s_keep = spike_out;
      for (int l = 0; l < LANES; l++) set_row(6, l, 200*256, 77, 50, 50, 1234, 99);
      for (int cyc = 0; cyc < 6; cyc++) begin
         @(negedge clk);
         drive_row(6);
         in_valid = 1'b0;
      end
      check("R6", out_valid === 1'b0, "out_valid", out_valid, 0);
      check("R6", v_out == v_keep, "v held", v_out[31:0], v_keep[31:0]);
      check("R6", u_out == u_keep, "u held", u_out[31:0], u_keep[31:0]);
      check("R6", spike_out == s_keep, "spike held", spike_out, s_keep);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_subthreshold;
      t_threshold;
      t_param_sets;
      t_stream;
      t_hold;
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule